// File: doc/BRIEF.md
# Merged-State Pattern Matcher with Path Tracking

This block scans a byte stream against a set of patterns with a compressed automaton. States from different patterns that differ only in where they lead share one table row. Because a shared row no longer knows which pattern brought the scan there, each row carries a path mask with one bit per pattern plus a single final flag. A per-pattern match vector is not stored. The block keeps a running mask of the patterns that are still consistent with the bytes seen so far, and it reports a hit only when that mask still has a surviving bit on arrival at a final row. This removes the false hits that sharing rows would otherwise create.

Software or a loader fills two tables through the load port before scanning starts. The transition table holds, for each (state, byte) pair, the next state and whether the step moves forward along a pattern or is a fallback/restart. The row table holds each state's path mask and final flag. Bytes are then presented one per cycle with a valid qualifier. The hit strobe, the bits of the matched patterns and the running mask all come from registers and change one cycle after the byte that caused them.

Top module: `mm_merged_matcher`

## Requirements
- R1: While reset (rst_n low) is asserted and after its release, the automaton sits in state 0, `live_paths` is all ones, and `match` and `match_pat` are zero.
- R2: When `in_valid` is high at a rising edge, the next state is the one stored in the transition-table entry addressed by the current state and `in_byte`.
- R3: A step whose table entry has its forward flag set (`ld_fwd`=1 when loaded) sets `live_paths` to the bitwise AND of its previous value and the next state's path mask.
- R4: A step whose entry has the forward flag clear sets `live_paths` to the next state's path mask. The previous mask is discarded.
- R5: One cycle after a valid byte, `match` is 1 exactly when the entered state's final flag is set and the new `live_paths` is nonzero. In that cycle `match_pat` equals the new `live_paths`. Otherwise `match_pat` is zero.
- R6: A cycle with `in_valid` low leaves the state and `live_paths` unchanged, and `match` and `match_pat` are zero after it.
- R7: `ld_trans_we` writes the entry (`ld_state`, `ld_sym`) with `ld_next`/`ld_fwd`, and `ld_info_we` writes row `ld_state` with `ld_path`/`ld_final`. Later steps use the new contents, and a load by itself does not change any output.
- R8: A byte sequence that leads the shared rows into a final state along a path belonging to a different pattern (mask becomes zero) produces no `match`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_byte` this cycle |
| in_byte | input | 8 | Stream byte |
| ld_trans_we | input | 1 | Write one transition-table entry |
| ld_info_we | input | 1 | Write one row's path mask and final flag |
| ld_state | input | ST_W (3) | State addressed by a load |
| ld_sym | input | 8 | Byte addressed by a transition load |
| ld_next | input | ST_W (3) | Next state to store |
| ld_fwd | input | 1 | 1 = forward step, 0 = fallback/restart step |
| ld_path | input | NUM_PAT (4) | Path mask to store |
| ld_final | input | 1 | Final flag to store |
| match | output | 1 | Hit strobe, one cycle after the last byte |
| match_pat | output | NUM_PAT (4) | Patterns hit, zero when no hit |
| live_paths | output | NUM_PAT (4) | Running mask of feasible patterns |

## Verification
The hardest case to reach is a hit that is suppressed: the scan has to enter a final shared row along a prefix that belongs to another pattern, and the mask has to drop to zero only on the last byte. The bench loads a two-pattern table in which the middle rows are shared. It then feeds sequences that cross from one pattern's opening byte into the other's ending, and it also restarts partway through a pattern so that the reload path runs. A behavioural model of the table and mask is compared on every clock. Separate checks confirm the suppressed hit, the real hits, the reload value and the effect of rewriting a row in the middle of a run.

// File: rtl/mm_pkg.sv
package mm_pkg;
   localparam int MM_SYM_W = 8;
   localparam int MM_SYMS  = 1 << MM_SYM_W;

   typedef enum logic {
      STEP_RELOAD = 1'b0,
      STEP_FWD    = 1'b1
   } step_e;
endpackage

// File: rtl/mm_trans_table.sv
module mm_trans_table
   import mm_pkg::*;
#(
   parameter int NUM_STATES = 8,
   parameter int ST_W       = 3
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [ST_W-1:0]     wr_state,
   input  logic [MM_SYM_W-1:0] wr_sym,
   input  logic [ST_W-1:0]     wr_next,
   input  step_e               wr_kind,
   input  logic [ST_W-1:0]     rd_state,
   input  logic [MM_SYM_W-1:0] rd_sym,
   output logic [ST_W-1:0]     rd_next,
   output step_e               rd_kind
);
   logic [ST_W-1:0] next_mem [NUM_STATES][MM_SYMS];
   step_e           kind_mem [NUM_STATES][MM_SYMS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         next_mem[wr_state][wr_sym] <= wr_next;
         kind_mem[wr_state][wr_sym] <= wr_kind;
      end
   end

   assign rd_next = next_mem[rd_state][rd_sym];
   assign rd_kind = kind_mem[rd_state][rd_sym];
endmodule

// File: rtl/mm_state_rows.sv
module mm_state_rows #(
   parameter int NUM_STATES = 8,
   parameter int NUM_PAT    = 4,
   parameter int ST_W       = 3
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [ST_W-1:0]    wr_state,
   input  logic [NUM_PAT-1:0] wr_path,
   input  logic               wr_final,
   input  logic [ST_W-1:0]    rd_state,
   output logic [NUM_PAT-1:0] rd_path,
   output logic               rd_final
);
   logic [NUM_PAT-1:0] path_all  [NUM_STATES];
   logic               final_all [NUM_STATES];

   for (genvar i = 0; i < NUM_STATES; i++) begin : g_row
      logic [NUM_PAT-1:0] path_q;
      logic               final_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_state == ST_W'(i))) begin
            path_q  <= wr_path;
            final_q <= wr_final;
         end
      end
      assign path_all[i]  = path_q;
      assign final_all[i] = final_q;
   end

   assign rd_path  = path_all[rd_state];
   assign rd_final = final_all[rd_state];
endmodule

// File: rtl/mm_path_tracker.sv
module mm_path_tracker
   import mm_pkg::*;
#(
   parameter int NUM_PAT = 4,
   parameter int ST_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic [ST_W-1:0]    nxt_state,
   input  step_e              nxt_kind,
   input  logic [NUM_PAT-1:0] nxt_path,
   input  logic               nxt_final,
   output logic [ST_W-1:0]    cur_state,
   output logic [NUM_PAT-1:0] live,
   output logic               hit,
   output logic [NUM_PAT-1:0] hit_pat
);
   logic [NUM_PAT-1:0] live_n;

   always_comb begin
      if (nxt_kind == STEP_FWD) live_n = live & nxt_path;
      else                      live_n = nxt_path;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_state <= '0;
         live      <= '1;
         hit       <= 1'b0;
         hit_pat   <= '0;
      end else begin
         hit     <= 1'b0;
         hit_pat <= '0;
         if (step) begin
            cur_state <= nxt_state;
            live      <= live_n;
            if (nxt_final && (live_n != '0)) begin
               hit     <= 1'b1;
               hit_pat <= live_n;
            end
         end
      end
   end

   a_r5_hit_has_paths: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (hit_pat != '0));
   a_r5_quiet_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_pat == '0));
   a_r3_fwd_narrows: assert property (@(posedge clk) disable iff (!rst_n)
      (step && nxt_kind == STEP_FWD) |=> ((live & ~$past(live)) == '0));
   a_r4_reload_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (step && nxt_kind == STEP_RELOAD) |=> (live == $past(nxt_path)));
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(live) && $stable(cur_state) && !hit));
endmodule

// File: rtl/mm_merged_matcher.sv
module mm_merged_matcher
   import mm_pkg::*;
#(
   parameter int NUM_STATES = 8,
   parameter int NUM_PAT    = 4,
   parameter int ST_W       = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [7:0]         in_byte,
   input  logic               ld_trans_we,
   input  logic               ld_info_we,
   input  logic [ST_W-1:0]    ld_state,
   input  logic [7:0]         ld_sym,
   input  logic [ST_W-1:0]    ld_next,
   input  logic               ld_fwd,
   input  logic [NUM_PAT-1:0] ld_path,
   input  logic               ld_final,
   output logic               match,
   output logic [NUM_PAT-1:0] match_pat,
   output logic [NUM_PAT-1:0] live_paths
);
   if (NUM_STATES < 2 || NUM_STATES > 64) begin : g_bad_states
      $error("NUM_STATES must lie in 2..64");
   end
   if (NUM_PAT < 1 || NUM_PAT > 32) begin : g_bad_pat
      $error("NUM_PAT must lie in 1..32");
   end
   if ((1 << ST_W) < NUM_STATES) begin : g_bad_stw
      $error("ST_W too narrow for NUM_STATES");
   end

   logic [ST_W-1:0]    cur_state;
   logic [ST_W-1:0]    nxt_state;
   step_e              nxt_kind;
   logic [NUM_PAT-1:0] nxt_path;
   logic               nxt_final;

   mm_trans_table #(.NUM_STATES(NUM_STATES), .ST_W(ST_W)) u_trans (
      .clk      (clk),
      .wr_en    (ld_trans_we),
      .wr_state (ld_state),
      .wr_sym   (ld_sym),
      .wr_next  (ld_next),
      .wr_kind  (ld_fwd ? STEP_FWD : STEP_RELOAD),
      .rd_state (cur_state),
      .rd_sym   (in_byte),
      .rd_next  (nxt_state),
      .rd_kind  (nxt_kind)
   );

   mm_state_rows #(.NUM_STATES(NUM_STATES), .NUM_PAT(NUM_PAT), .ST_W(ST_W)) u_rows (
      .clk      (clk),
      .wr_en    (ld_info_we),
      .wr_state (ld_state),
      .wr_path  (ld_path),
      .wr_final (ld_final),
      .rd_state (nxt_state),
      .rd_path  (nxt_path),
      .rd_final (nxt_final)
   );

   mm_path_tracker #(.NUM_PAT(NUM_PAT), .ST_W(ST_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (in_valid),
      .nxt_state (nxt_state),
      .nxt_kind  (nxt_kind),
      .nxt_path  (nxt_path),
      .nxt_final (nxt_final),
      .cur_state (cur_state),
      .live      (live_paths),
      .hit       (match),
      .hit_pat   (match_pat)
   );
endmodule

// File: tb/mm_merged_matcher_bench.sv
module mm_merged_matcher_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 8;
   localparam int NP = 4;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = '0;
   logic          ld_trans_we = 1'b0, ld_info_we = 1'b0;
   logic [SW-1:0] ld_state = '0, ld_next = '0;
   logic [7:0]    ld_sym = '0;
   logic          ld_fwd = 1'b0, ld_final = 1'b0;
   logic [NP-1:0] ld_path = '0;
   logic          match;
   logic [NP-1:0] match_pat, live_paths;

   always #(CLK_PERIOD/2) clk = ~clk;

   mm_merged_matcher #(.NUM_STATES(NS), .NUM_PAT(NP)) u_mm_merged_matcher (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .ld_trans_we(ld_trans_we), .ld_info_we(ld_info_we), .ld_state(ld_state),
      .ld_sym(ld_sym), .ld_next(ld_next), .ld_fwd(ld_fwd), .ld_path(ld_path),
      .ld_final(ld_final), .match(match), .match_pat(match_pat),
      .live_paths(live_paths)
   );

   int total = 0, fails = 0;
   bit done = 1'b0;

   // behavioural model
   int            m_next [NS][256];
   bit            m_fwd  [NS][256];
   logic [NP-1:0] m_path [NS];
   bit            m_final[NS];
   int            ms = 0;
   logic [NP-1:0] ml = '1;
   logic          mm = 1'b0;
   logic [NP-1:0] mp = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cmp_all(input string live_tag);
      chk("R5 match strobe", {31'd0, match}, {31'd0, mm});
      chk("R5 match_pat", {28'd0, match_pat}, {28'd0, mp});
      chk(live_tag, {28'd0, live_paths}, {28'd0, ml});
   endtask

   task automatic send(input byte b, input bit v);
      string tag;
      in_byte = b; in_valid = v;
      @(posedge clk);
      tag = "R6 idle hold";
      if (v) begin
         int nx;
         nx = m_next[ms][b];
         if (m_fwd[ms][b]) begin ml = ml & m_path[nx]; tag = "R3 forward AND"; end
         else begin ml = m_path[nx]; tag = "R4 reload"; end
         mm = m_final[nx] && (ml != '0);
         mp = mm ? ml : '0;
         ms = nx;
      end else begin
         mm = 1'b0; mp = '0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      cmp_all(tag);
   endtask

   task automatic send_str(input string s);
      for (int i = 0; i < s.len(); i++) send(s[i], 1'b1);
   endtask

   task automatic load_trans(input int st, input int sy, input int nx, input bit fw);
      ld_trans_we = 1'b1; ld_state = SW'(st); ld_sym = 8'(sy);
      ld_next = SW'(nx); ld_fwd = fw;
      @(posedge clk);
      m_next[st][sy] = nx; m_fwd[st][sy] = fw;
      mm = 1'b0; mp = '0;
      @(negedge clk);
      ld_trans_we = 1'b0;
   endtask

   task automatic load_info(input int st, input logic [NP-1:0] p, input bit f);
      ld_info_we = 1'b1; ld_state = SW'(st); ld_path = p; ld_final = f;
      @(posedge clk);
      m_path[st] = p; m_final[st] = f;
      mm = 1'b0; mp = '0;
      @(negedge clk);
      ld_info_we = 1'b0;
      cmp_all("R7 load leaves outputs");
   endtask

   // rows: 0 root, 1 after "b", 2 shared "?c", 3 shared "?cd", 4 end of bcdf,
   // 5 after "p", 6 end of pcdg. Pattern bit0 = bcdf, bit1 = pcdg.
   function automatic int tbl_next(int st, int sy, output bit fw);
      fw = 1'b0;
      if (st == 0 && sy == "b") begin fw = 1'b1; return 1; end
      if (st == 0 && sy == "p") begin fw = 1'b1; return 5; end
      if ((st == 1 || st == 5) && sy == "c") begin fw = 1'b1; return 2; end
      if (st == 2 && sy == "d") begin fw = 1'b1; return 3; end
      if (st == 3 && sy == "f") begin fw = 1'b1; return 4; end
      if (st == 3 && sy == "g") begin fw = 1'b1; return 6; end
      if (st < 7 && sy == "b") return 1;
      if (st < 7 && sy == "p") return 5;
      return 0;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      ms = 0; ml = '1; mm = 1'b0; mp = '0;
      chk("R1 reset live", {28'd0, live_paths}, 32'hF);
      chk("R1 reset match", {31'd0, match}, 32'd0);
      chk("R1 reset match_pat", {28'd0, match_pat}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_all("R1 after release");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R7: table load
      for (int st = 0; st < NS; st++)
         for (int sy = 0; sy < 256; sy++) begin
            bit fw; int nx;
            nx = tbl_next(st, sy, fw);
            load_trans(st, sy, nx, fw);
         end
      load_info(0, 4'b0011, 1'b0);
      load_info(1, 4'b0001, 1'b0);
      load_info(2, 4'b0011, 1'b0);
      load_info(3, 4'b0011, 1'b0);
      load_info(4, 4'b0001, 1'b1);
      load_info(5, 4'b0010, 1'b0);
      load_info(6, 4'b0010, 1'b1);
      load_info(7, 4'b0000, 1'b0);

      // R5/R2: genuine hits
      send_str("bcdf");
      chk("R5 bcdf hit", {31'd0, match}, 32'd1);
      chk("R5 bcdf pattern", {28'd0, match_pat}, 32'h1);
      send_str("pcdg");
      chk("R5 pcdg pattern", {28'd0, match_pat}, 32'h2);
      // R8: crossed paths through shared rows
      send_str("pcdf");
      chk("R8 pcdf suppressed", {31'd0, match}, 32'd0);
      chk("R8 pcdf mask empty", {28'd0, live_paths}, 32'h0);
      send_str("bcdg");
      chk("R8 bcdg suppressed", {31'd0, match}, 32'd0);
      // R4: restart in mid-pattern reloads the mask
      send_str("pcx");
      chk("R4 reload on fallback", {28'd0, live_paths}, 32'h3);
      send_str("bcbcdf");
      chk("R4 restart then hit", {28'd0, match_pat}, 32'h1);
      // R6: idle gaps inside a pattern
      send("p", 1'b1); send(8'h00, 1'b0); send("c", 1'b1);
      send(8'h00, 1'b0); send(8'h00, 1'b0); send("d", 1'b1); send("g", 1'b1);
      chk("R6 gaps keep progress", {31'd0, match}, 32'd1);
      send(8'h00, 1'b0);
      chk("R6 strobe single cycle", {31'd0, match}, 32'd0);
      // R7: rewrite a row mid-run
      load_info(4, 4'b0001, 1'b0);
      send_str("bcdf");
      chk("R7 cleared final", {31'd0, match}, 32'd0);
      load_info(4, 4'b0001, 1'b1);
      send_str("xbcdf");
      chk("R7 restored final", {31'd0, match}, 32'd1);
      // R2/R1: reset mid-run returns to root
      send_str("pc");
      do_reset();
      send("c", 1'b1);
      chk("R2 root on c", {28'd0, live_paths}, 32'h3);
      for (int k = 0; k < 40; k++) send(8'(k * 7 + 98), (k % 3) != 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule